// File: doc/BRIEF.md
# Message-Passing Double Buffer Controller

This block steers an incoming stream of variable-length messages into two receive buffers that alternate. Each word arrives with a write strobe. The last word of a message carries an end marker. The controller keeps a word count for the buffer that is currently filling. When the end marker arrives, it marks that buffer as holding a complete message and moves capture to the other buffer if that buffer is free. Software releases a buffer it has drained by pulsing the acknowledge bit for that buffer. When both buffers hold messages, the controller waits for a release.

Two error conditions are kept as sticky flags. The first is a message that runs past the buffer size. The second is a word that arrives while both buffers are still held. Neither flag alters the buffer hand-off. Each flag is cleared by a one-cycle pulse on its own clear input. Word storage and the transfer to memory sit outside this block, which only exposes its state, the active-buffer select, the held flags and the word count.

Top module: `msg_pingpong_ctrl`

## Requirements
- R1: After synchronous reset, `state_o` is 0, `active_o` is 0, `full_o` is 00, `fill_count_o` is 0, and both error flags are 0.
- R2: A write without the end marker, while not both buffers are held and the count is below DEPTH, raises `fill_count_o` by one and leaves the buffer select and held flags unchanged.
- R3: A write with the end marker, while not both buffers are held, sets `full_o` for the active buffer and clears the count. Capture moves to the other buffer if that buffer is free after this cycle's acknowledges. Otherwise both buffers are held.
- R4: With both buffers held, acknowledging one buffer frees it and makes it active. Acknowledging both at once frees both and makes buffer 0 active. The count restarts at 0 in both cases.
- R5: An acknowledge for a buffer whose `full_o` bit is 0 has no effect.
- R6: A write while both buffers are held is dropped, does not change the count, and sets `overrun_o`.
- R7: A write while the count equals DEPTH is not counted and sets `overflow_o`. If it carries the end marker, it still closes the buffer as in R3.
- R8: Both flags are sticky. A one-cycle pulse on the matching clear input clears a flag, but a set in the same cycle wins over the clear. The flags never change the state, the select, the held flags or the count.
- R9: The encoding of `state_o` is 0 when filling buffer 0, 1 when filling buffer 1, and 2 when both buffers are held. `full_o[i]` and `active_o` value i refer to buffer i.
- R10: When exactly one buffer is held and the other is filling, acknowledging the held buffer frees it and changes neither the select nor the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_i | input | 1 | Word arrives for the active buffer |
| last_i | input | 1 | Qualifies the write as the last word of a message |
| ack_i | input | 2 | Per-buffer release from software, bit i for buffer i |
| clr_overrun_i | input | 1 | Clears the overrun flag |
| clr_overflow_i | input | 1 | Clears the overflow flag |
| state_o | output | 2 | 0 filling buffer 0, 1 filling buffer 1, 2 both held |
| active_o | output | 1 | Index of the buffer being filled |
| full_o | output | 2 | Held (message complete) flag per buffer |
| fill_count_o | output | CW | Words counted in the active buffer |
| overrun_o | output | 1 | Sticky: write arrived with both buffers held |
| overflow_o | output | 1 | Sticky: message longer than DEPTH |

## Verification
The bench first runs directed sequences. These walk short messages through both buffers and back. They acknowledge free buffers to show the acknowledge is ignored. They pile messages until both buffers are held to separate single and double releases. They push one word past DEPTH to split overflow from a normal close. They pulse the clears, both alone and together with a new error, to tell clear priority from set priority. A long pseudo-random sweep, with a small DEPTH, then mixes writes, end markers, acknowledges and clears in every combination. Each output is compared every cycle against an arithmetic model built from the requirements, which catches hand-off and count errors that appear only under rare overlaps.

// File: rtl/msg_pingpong_pkg.sv
package msg_pingpong_pkg;

  typedef enum logic [1:0] {
    ST_FILL_A = 2'd0,
    ST_FILL_B = 2'd1,
    ST_HOLD   = 2'd2
  } mp_state_e;

  localparam int NUM_BUFS = 2;

endpackage

// File: rtl/msg_pingpong_counter.sv
module msg_pingpong_counter #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc_i,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o,
  output logic          at_cap_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + CW'(1);
  end

  assign cnt_o    = cnt_q;
  assign at_cap_o = (cnt_q == CW'(DEPTH));

endmodule

// File: rtl/msg_pingpong_flag.sv
module msg_pingpong_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  logic q;

  always_ff @(posedge clk) begin
    if (rst)        q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end

  assign q_o = q;

endmodule

// File: rtl/msg_pingpong_fsm.sv
module msg_pingpong_fsm
  import msg_pingpong_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_i,
  input  logic                last_i,
  input  logic [NUM_BUFS-1:0] ack_i,
  input  logic                at_cap_i,
  output mp_state_e           state_o,
  output logic                active_o,
  output logic [NUM_BUFS-1:0] full_o,
  output logic                cnt_inc_o,
  output logic                cnt_clr_o,
  output logic                overrun_evt_o,
  output logic                overflow_evt_o
);

  mp_state_e           state_q, state_n;
  logic                act_q, act_n;
  logic [NUM_BUFS-1:0] full_q, full_n;
  logic [NUM_BUFS-1:0] ack_eff;
  logic                both_held;
  logic                other;

  assign ack_eff   = ack_i & full_q;
  assign both_held = (state_q == ST_HOLD);
  assign other     = ~act_q;

  always_comb begin
    full_n         = full_q & ~ack_eff;
    act_n          = act_q;
    cnt_inc_o      = 1'b0;
    cnt_clr_o      = 1'b0;
    overrun_evt_o  = 1'b0;
    overflow_evt_o = 1'b0;
    if (both_held) begin
      overrun_evt_o = wr_i;
      if (ack_eff == 2'b11)   act_n = 1'b0;
      else if (ack_eff[0])    act_n = 1'b0;
      else if (ack_eff[1])    act_n = 1'b1;
      if (|ack_eff) cnt_clr_o = 1'b1;
    end else if (wr_i) begin
      if (at_cap_i) overflow_evt_o = 1'b1;
      else          cnt_inc_o      = 1'b1;
      if (last_i) begin
        full_n[act_q] = 1'b1;
        cnt_clr_o     = 1'b1;
        if (!full_n[other]) act_n = other;
      end
    end
  end

  always_comb begin
    if (full_n == 2'b11) state_n = ST_HOLD;
    else if (act_n)      state_n = ST_FILL_B;
    else                 state_n = ST_FILL_A;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_FILL_A;
      act_q   <= 1'b0;
      full_q  <= '0;
    end else begin
      state_q <= state_n;
      act_q   <= act_n;
      full_q  <= full_n;
    end
  end

  assign state_o  = state_q;
  assign active_o = act_q;
  assign full_o   = full_q;

endmodule

// File: rtl/msg_pingpong_ctrl.sv
module msg_pingpong_ctrl
  import msg_pingpong_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_i,
  input  logic          last_i,
  input  logic [1:0]    ack_i,
  input  logic          clr_overrun_i,
  input  logic          clr_overflow_i,
  output logic [1:0]    state_o,
  output logic          active_o,
  output logic [1:0]    full_o,
  output logic [CW-1:0] fill_count_o,
  output logic          overrun_o,
  output logic          overflow_o
);

  localparam int NFLAGS = 2;

  mp_state_e         st;
  logic              cnt_inc, cnt_clr, at_cap;
  logic              ovr_evt, ovf_evt;
  logic [NFLAGS-1:0] flag_set, flag_clr, flag_q;

  msg_pingpong_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .wr_i          (wr_i),
    .last_i        (last_i),
    .ack_i         (ack_i),
    .at_cap_i      (at_cap),
    .state_o       (st),
    .active_o      (active_o),
    .full_o        (full_o),
    .cnt_inc_o     (cnt_inc),
    .cnt_clr_o     (cnt_clr),
    .overrun_evt_o (ovr_evt),
    .overflow_evt_o(ovf_evt)
  );

  msg_pingpong_counter #(.DEPTH(DEPTH)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .inc_i   (cnt_inc),
    .clr_i   (cnt_clr),
    .cnt_o   (fill_count_o),
    .at_cap_o(at_cap)
  );

  assign flag_set = {ovf_evt, ovr_evt};
  assign flag_clr = {clr_overflow_i, clr_overrun_i};

  for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
    msg_pingpong_flag u_flag (
      .clk  (clk),
      .rst  (rst),
      .set_i(flag_set[g]),
      .clr_i(flag_clr[g]),
      .q_o  (flag_q[g])
    );
  end

  assign state_o    = st;
  assign overrun_o  = flag_q[0];
  assign overflow_o = flag_q[1];

endmodule

// File: rtl/msg_pingpong_ctrl_chk.sv
module msg_pingpong_ctrl_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_i,
  input logic          last_i,
  input logic [1:0]    ack_i,
  input logic          clr_overrun_i,
  input logic          clr_overflow_i,
  input logic [1:0]    state_o,
  input logic          active_o,
  input logic [1:0]    full_o,
  input logic [CW-1:0] fill_count_o,
  input logic          overrun_o,
  input logic          overflow_o
);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (active_o == 1'b0 && full_o == 2'b00 && !overrun_o && !overflow_o)); // R1

  AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (wr_i && last_i && full_o != 2'b11 && !active_o) |=> full_o[0]); // R3

  AST_SWITCH_TO_FREE: assert property (@(posedge clk) disable iff (rst)
    (wr_i && last_i && full_o == 2'b00 && ack_i == 2'b00) |=> (active_o != $past(active_o))); // R3

  AST_DOUBLE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (full_o == 2'b11 && ack_i == 2'b11) |=> (full_o == 2'b00 && !active_o)); // R4

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (rst)
    (wr_i && full_o == 2'b11) |=> overrun_o); // R6

  AST_NO_OVERFLOW_MISS: assert property (@(posedge clk) disable iff (rst)
    (wr_i && full_o != 2'b11 && fill_count_o == CW'(DEPTH)) |=> overflow_o); // R7

  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
    (overflow_o && !clr_overflow_i) |=> overflow_o); // R8

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    (overrun_o && !clr_overrun_i) |=> overrun_o); // R8

  AST_HOLD_CODE: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd2) == (full_o == 2'b11)); // R9

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    fill_count_o <= CW'(DEPTH)); // R7

endmodule

bind msg_pingpong_ctrl msg_pingpong_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .wr_i          (wr_i),
  .last_i        (last_i),
  .ack_i         (ack_i),
  .clr_overrun_i (clr_overrun_i),
  .clr_overflow_i(clr_overflow_i),
  .state_o       (state_o),
  .active_o      (active_o),
  .full_o        (full_o),
  .fill_count_o  (fill_count_o),
  .overrun_o     (overrun_o),
  .overflow_o    (overflow_o)
);

// File: tb/msg_pingpong_ctrl_tb.sv
module msg_pingpong_ctrl_tb;

  localparam int DEPTH = 4;
  localparam int CW = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_i = 1'b0, last_i = 1'b0;
  logic [1:0]    ack_i = 2'b00;
  logic          clr_overrun_i = 1'b0, clr_overflow_i = 1'b0;
  logic [1:0]    state_o;
  logic          active_o;
  logic [1:0]    full_o;
  logic [CW-1:0] fill_count_o;
  logic          overrun_o, overflow_o;

  int checks = 0;
  int errors = 0;

  int m_act, m_full, m_cnt, m_ovr, m_ovf, m_state;

  always #5 clk = ~clk;

  msg_pingpong_ctrl #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .wr_i(wr_i), .last_i(last_i), .ack_i(ack_i),
    .clr_overrun_i(clr_overrun_i), .clr_overflow_i(clr_overflow_i),
    .state_o(state_o), .active_o(active_o), .full_o(full_o),
    .fill_count_o(fill_count_o), .overrun_o(overrun_o), .overflow_o(overflow_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_act = 0; m_full = 0; m_cnt = 0; m_ovr = 0; m_ovf = 0; m_state = 0;
  endtask

  task automatic model_step(input bit w, input bit l, input int a, input bit co, input bit cf);
    int ackd, nf, na, oth;
    bit sovr, sovf;
    ackd = a & m_full;
    nf = m_full & ~ackd;
    na = m_act;
    sovr = 0; sovf = 0;
    if (m_full == 3) begin
      sovr = w;
      if (ackd == 3 || ackd == 1) na = 0;
      else if (ackd == 2) na = 1;
      if (ackd != 0) m_cnt = 0;
    end else if (w) begin
      if (m_cnt == DEPTH) sovf = 1; else m_cnt = m_cnt + 1;
      if (l) begin
        nf = nf | (1 << m_act);
        m_cnt = 0;
        oth = 1 - m_act;
        if (((nf >> oth) & 1) == 0) na = oth;
      end
    end
    m_full = nf; m_act = na;
    m_state = (nf == 3) ? 2 : na;
    if (sovr) m_ovr = 1; else if (co) m_ovr = 0;
    if (sovf) m_ovf = 1; else if (cf) m_ovf = 0;
  endtask

  task automatic compare_all();
    chk("R9 state", state_o, m_state);
    chk("R3 active", active_o, m_act);
    chk("R3 full", full_o, m_full);
    chk("R2 count", fill_count_o, m_cnt);
    chk("R6 overrun", overrun_o, m_ovr);
    chk("R7 overflow", overflow_o, m_ovf);
  endtask

  task automatic step(input bit w, input bit l, input logic [1:0] a,
                      input bit co, input bit cf, input bit cmp);
    @(negedge clk);
    wr_i = w; last_i = l; ack_i = a; clr_overrun_i = co; clr_overflow_i = cf;
    @(posedge clk);
    #1;
    model_step(w, l, int'(a), co, cf);
    if (cmp) compare_all();
    wr_i = 0; last_i = 0; ack_i = 0; clr_overrun_i = 0; clr_overflow_i = 0;
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset values
    chk("R1 state", state_o, 0);
    chk("R1 active", active_o, 0);
    chk("R1 full", full_o, 0);
    chk("R1 count", fill_count_o, 0);
    chk("R1 flags", {overrun_o, overflow_o}, 0);

    // R2: three plain words
    for (int i = 0; i < 3; i++) step(1, 0, 2'b00, 0, 0, 0);
    chk("R2 count after 3 words", fill_count_o, 3);
    chk("R2 active unchanged", active_o, 0);

    // R5: acks on free buffers ignored
    step(0, 0, 2'b11, 0, 0, 0);
    chk("R5 full after stray ack", full_o, 0);
    chk("R5 count after stray ack", fill_count_o, 3);

    // R3: close buffer 0
    step(1, 1, 2'b00, 0, 0, 0);
    chk("R3 full", full_o, 1);
    chk("R3 active moved", active_o, 1);
    chk("R9 state fill B", state_o, 1);
    chk("R3 count cleared", fill_count_o, 0);

    // R10: release buffer 0 while B fills
    step(1, 0, 2'b00, 0, 0, 0);
    step(0, 0, 2'b01, 0, 0, 0);
    chk("R10 full freed", full_o, 0);
    chk("R10 active kept", active_o, 1);
    chk("R10 count kept", fill_count_o, 1);

    // R3: both held
    step(1, 1, 2'b00, 0, 0, 0);
    step(1, 1, 2'b00, 0, 0, 0);
    chk("R3 both held", full_o, 3);
    chk("R9 hold code", state_o, 2);

    // R6: write in hold
    step(1, 0, 2'b00, 0, 0, 0);
    chk("R6 overrun set", overrun_o, 1);
    chk("R6 count unchanged", fill_count_o, 0);
    chk("R8 full unaffected by flag", full_o, 3);

    // R4: single release of buffer 1
    step(0, 0, 2'b10, 0, 0, 0);
    chk("R4 single release full", full_o, 1);
    chk("R4 single release active", active_o, 1);

    // refill to hold then double release
    step(1, 1, 2'b00, 0, 0, 0);
    chk("R3 hold again", state_o, 2);
    step(0, 0, 2'b11, 0, 0, 0);
    chk("R4 double release full", full_o, 0);
    chk("R4 double release active", active_o, 0);
    chk("R4 double release count", fill_count_o, 0);

    // R7: overflow
    for (int i = 0; i < DEPTH + 1; i++) step(1, 0, 2'b00, 0, 0, 0);
    chk("R7 overflow set", overflow_o, 1);
    chk("R7 count capped", fill_count_o, DEPTH);
    step(1, 1, 2'b00, 0, 0, 0);
    chk("R7 last still closes", full_o, 1);
    chk("R7 active moved", active_o, 1);

    // R8: clear and set-wins
    step(0, 0, 2'b00, 1, 1, 0);
    chk("R8 overflow cleared", overflow_o, 0);
    chk("R8 overrun cleared", overrun_o, 0);
    for (int i = 0; i < DEPTH; i++) step(1, 0, 2'b00, 0, 0, 0);
    step(1, 0, 2'b00, 0, 1, 0);
    chk("R8 set wins over clear", overflow_o, 1);
    step(0, 0, 2'b00, 0, 0, 0);
    chk("R8 sticky hold", overflow_o, 1);

    // pseudo-random sweep against model
    lfsr = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      bit w, l, co, cf;
      logic [1:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      w  = lfsr[0] | lfsr[1];
      l  = lfsr[2] & lfsr[3] & lfsr[4];
      a  = {lfsr[5] & lfsr[6] & lfsr[7], lfsr[8] & lfsr[9] & lfsr[7]};
      co = lfsr[10] & lfsr[11] & lfsr[12];
      cf = lfsr[13] & lfsr[14] & lfsr[11];
      step(w, l, a, co, cf, 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule